// File: doc/BRIEF.md
# Idempotency Violation Tracker

This block watches the data-side memory traffic of a processor over an interval that ends with each report pulse. It sorts every word address inside the RAM window by the kind of its first access in the interval. It keeps a read-first set, a write-first set and a conflict set, each a small content-addressable array. A store that hits an address whose first access was a load breaks re-execution safety: the block raises a one-cycle violation pulse and counts the conflict.

A report pulse freezes the interval's write, read, conflict and near-stack conflict counts, along with the number of cycles the interval lasted, into output registers. The same pulse empties all three sets and restarts every counter. Instruction fetches can optionally be treated as loads. Stores to one configured address are never tracked. Loads marked as debug or false reads pass through without being recorded.

Top module: `idem_tracker`

## Requirements
- R1: While reset is held and right after it is released, `viol_o`, `rpt_valid_o` and `overflow_o` are 0. The first interval starts with every count at zero.
- R2: A load to a RAM word that is in neither the read-first set nor the write-first set adds the word to the read-first set and raises the read count by one. A second load to the same word in the same interval does not change the count.
- R3: A load to a word already in the write-first set is not recorded. A later store to that word in the same interval gives no violation.
- R4: A store to a word in the read-first set drives `viol_o` high for exactly the one cycle after the store's clock edge. Every such store gives its own pulse.
- R5: The conflict count rises only on the first violating store to a given word in an interval. Repeat violations at that word leave it unchanged.
- R6: A first conflict at word address A raises the stack count when A + STACK_SLACK >= `sp_i`, that is, when A is at or above the stack pointer minus 8 words (32 bytes). Below that, the stack count is unchanged.
- R7: A store to a word not in the read-first set adds the word to the write-first set. The write count rises only when the word is newly added.
- R8: Stores to word address IGNORE_ADDR give no violation and do not change the write count. Loads to that address are tracked as usual.
- R9: Accesses outside the window RAM_BASE <= A < RAM_BASE + RAM_WORDS are not tracked. With the defaults, that window is 0x1000 to 0x1FFF.
- R10: A load with `acc_bypass_i` set is not tracked. A later store to that word gives no violation and counts as a new write.
- R11: A report pulse makes `rpt_valid_o` high in the next cycle, carrying the interval's write, read, conflict and stack counts. All counts and all three sets are then empty for the next interval. A data access presented in the report cycle is discarded.
- R12: An insert into a full set (DEPTH entries) is dropped and does not count. It sets `overflow_o`, which stays set until the next report clears it.
- R13: `rpt_cycles_o` gives the number of clock edges from the previous report, or from the release of reset, up to and including this report's edge. Two back-to-back reports give 1.
- R14: With TRACK_FETCH = 1, a fetch in a cycle with no data access is tracked exactly as a load. A fetch in the same cycle as a data access is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid_i | input | 1 | Data access present this cycle |
| acc_write_i | input | 1 | 1 = store, 0 = load |
| acc_bypass_i | input | 1 | Load is a debug or false read; skip tracking |
| acc_addr_i | input | ADDR_W | Word address of the data access |
| fetch_valid_i | input | 1 | Instruction fetch present this cycle |
| fetch_addr_i | input | ADDR_W | Word address of the fetch |
| sp_i | input | ADDR_W | Current stack pointer as a word address |
| report_i | input | 1 | Snapshot counts and start a new interval |
| viol_o | output | 1 | One-cycle violation pulse |
| rpt_valid_o | output | 1 | Snapshot outputs updated this cycle |
| rpt_writes_o | output | CNT_W | Write-first words in the interval |
| rpt_reads_o | output | CNT_W | Read-first words in the interval |
| rpt_conflicts_o | output | CNT_W | Distinct conflicting words |
| rpt_stack_o | output | CNT_W | Distinct conflicts near the stack |
| rpt_cycles_o | output | CYC_W | Interval length in cycles |
| overflow_o | output | 1 | Sticky: a set insert was dropped |

## Verification
A corrupted set entry shows up only as a wrong violation decision, or a wrong new-entry decision, on a later access to the same word. Each scenario therefore returns to addresses it touched earlier and checks `viol_o` one cycle after each store. Counter and set-clear faults stay hidden until the next report. Every interval is therefore closed with a report whose snapshot is compared, and the first store of the following interval shows whether the sets were really emptied. A report presented together with a load, an overfilled read-first set, and a pair of back-to-back reports cover the ordering and boundary corners.

// File: rtl/idem_pkg.sv
package idem_pkg;
   typedef enum logic [1:0] {
      ACC_NONE  = 2'd0,
      ACC_LOAD  = 2'd1,
      ACC_STORE = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/idem_cam.sv
module idem_cam #(
   parameter int AW    = 30,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic [AW-1:0] key,
   input  logic          ins,
   output logic          hit,
   output logic          full
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2) begin : g_bad_depth
      $error("idem_cam: DEPTH must be at least 2");
   end

   logic [DEPTH-1:0] valid;
   logic [AW-1:0]    tag [DEPTH];
   logic [DEPTH-1:0] match;
   logic [IW-1:0]    free_idx;

   for (genvar g = 0; g < DEPTH; g++) begin : g_match
      assign match[g] = valid[g] && (tag[g] == key);
   end

   assign hit  = |match;
   assign full = &valid;

   always_comb begin
      free_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (!valid[i]) free_idx = IW'(i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= '0;
         for (int i = 0; i < DEPTH; i++) tag[i] <= '0;
      end else if (clr) begin
         valid <= '0;
      end else if (ins && !hit && !full) begin
         valid[free_idx] <= 1'b1;
         tag[free_idx]   <= key;
      end
   end

   // R2
   cam_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && ins && !hit && !full && !clr) |->
         ($countones(valid) == $countones($past(valid)) + 1));

   // R11
   cam_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (valid == '0));
endmodule

// File: rtl/idem_sat_cnt.sv
module idem_sat_cnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] MAXV = '1;

   if (W < 1) begin : g_bad_w
      $error("idem_sat_cnt: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 q <= '0;
      else if (clr)               q <= '0;
      else if (inc && q != MAXV)  q <= q + 1'b1;
   end

   // R7
   cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> (q == $past(q)));

   // R11
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0));
endmodule

// File: rtl/idem_tracker.sv
module idem_tracker
   import idem_pkg::*;
#(
   parameter int          ADDR_W      = 30,
   parameter int          DEPTH       = 16,
   parameter int          CNT_W       = 16,
   parameter int          CYC_W       = 32,
   parameter int unsigned RAM_BASE    = 32'h0000_1000,
   parameter int unsigned RAM_WORDS   = 32'h0000_1000,
   parameter int unsigned IGNORE_ADDR = 32'h0000_1FF0,
   parameter int unsigned STACK_SLACK = 8,
   parameter bit          TRACK_FETCH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid_i,
   input  logic              acc_write_i,
   input  logic              acc_bypass_i,
   input  logic [ADDR_W-1:0] acc_addr_i,
   input  logic              fetch_valid_i,
   input  logic [ADDR_W-1:0] fetch_addr_i,
   input  logic [ADDR_W-1:0] sp_i,
   input  logic              report_i,
   output logic              viol_o,
   output logic              rpt_valid_o,
   output logic [CNT_W-1:0]  rpt_writes_o,
   output logic [CNT_W-1:0]  rpt_reads_o,
   output logic [CNT_W-1:0]  rpt_conflicts_o,
   output logic [CNT_W-1:0]  rpt_stack_o,
   output logic [CYC_W-1:0]  rpt_cycles_o,
   output logic              overflow_o
);
   localparam int XW = 33;
   localparam logic [XW-1:0] WIN_LO  = XW'(RAM_BASE);
   localparam logic [XW-1:0] WIN_HI  = XW'(RAM_BASE) + XW'(RAM_WORDS);
   localparam logic [XW-1:0] IGN_X   = XW'(IGNORE_ADDR);
   localparam logic [XW-1:0] SLACK_X = XW'(STACK_SLACK);

   if (ADDR_W < 2 || ADDR_W > 32) begin : g_bad_aw
      $error("idem_tracker: ADDR_W must be within 2..32");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("idem_tracker: DEPTH must be at least 2");
   end
   if (CNT_W <= $clog2(DEPTH)) begin : g_bad_cnt
      $error("idem_tracker: CNT_W too narrow for DEPTH");
   end
   if (CYC_W < 2) begin : g_bad_cyc
      $error("idem_tracker: CYC_W must be at least 2");
   end
   if (RAM_WORDS == 0) begin : g_bad_win
      $error("idem_tracker: RAM_WORDS must be non-zero");
   end

   acc_kind_e         kind;
   logic [ADDR_W-1:0] sel_addr;

   if (TRACK_FETCH) begin : g_fetch
      always_comb begin
         kind = ACC_NONE;
         if (report_i)          kind = ACC_NONE;
         else if (acc_valid_i)  kind = acc_write_i ? ACC_STORE
                                    : (acc_bypass_i ? ACC_NONE : ACC_LOAD);
         else if (fetch_valid_i) kind = ACC_LOAD;
      end
      assign sel_addr = acc_valid_i ? acc_addr_i : fetch_addr_i;
   end else begin : g_nofetch
      logic unused_fetch;
      assign unused_fetch = ^{fetch_valid_i, fetch_addr_i};
      always_comb begin
         kind = ACC_NONE;
         if (!report_i && acc_valid_i)
            kind = acc_write_i ? ACC_STORE
                 : (acc_bypass_i ? ACC_NONE : ACC_LOAD);
      end
      assign sel_addr = acc_addr_i;
   end

   logic [XW-1:0] addr_x, sp_x;
   logic in_ram, is_ign, near_stack;
   logic is_load, is_store;

   assign addr_x     = {{(XW-ADDR_W){1'b0}}, sel_addr};
   assign sp_x       = {{(XW-ADDR_W){1'b0}}, sp_i};
   assign in_ram     = (addr_x >= WIN_LO) && (addr_x < WIN_HI);
   assign is_ign     = (addr_x == IGN_X);
   assign near_stack = (addr_x + SLACK_X) >= sp_x;
   assign is_load    = (kind == ACC_LOAD)  && in_ram;
   assign is_store   = (kind == ACC_STORE) && in_ram && !is_ign;

   logic rf_hit, rf_full, wf_hit, wf_full, cf_hit, cf_full;
   logic rf_ins, wf_ins, cf_ins;

   idem_cam #(.AW(ADDR_W), .DEPTH(DEPTH)) u_rf (
      .clk(clk), .rst_n(rst_n), .clr(report_i), .key(sel_addr),
      .ins(rf_ins), .hit(rf_hit), .full(rf_full));

   idem_cam #(.AW(ADDR_W), .DEPTH(DEPTH)) u_wf (
      .clk(clk), .rst_n(rst_n), .clr(report_i), .key(sel_addr),
      .ins(wf_ins), .hit(wf_hit), .full(wf_full));

   idem_cam #(.AW(ADDR_W), .DEPTH(DEPTH)) u_cf (
      .clk(clk), .rst_n(rst_n), .clr(report_i), .key(sel_addr),
      .ins(cf_ins), .hit(cf_hit), .full(cf_full));

   logic conflict;
   logic rd_new, wr_new, cf_new, stk_new;
   logic drop_any;

   assign rf_ins   = is_load && !wf_hit;
   assign conflict = is_store && rf_hit;
   assign cf_ins   = conflict;
   assign wf_ins   = is_store && !rf_hit;

   assign rd_new  = rf_ins && !rf_hit && !rf_full;
   assign wr_new  = wf_ins && !wf_hit && !wf_full;
   assign cf_new  = cf_ins && !cf_hit && !cf_full;
   assign stk_new = cf_new && near_stack;

   assign drop_any = (rf_ins && !rf_hit && rf_full) ||
                     (wf_ins && !wf_hit && wf_full) ||
                     (cf_ins && !cf_hit && cf_full);

   logic [CNT_W-1:0] wr_q, rd_q, cf_q, stk_q;

   idem_sat_cnt #(.W(CNT_W)) u_cnt_wr (
      .clk(clk), .rst_n(rst_n), .clr(report_i), .inc(wr_new), .q(wr_q));
   idem_sat_cnt #(.W(CNT_W)) u_cnt_rd (
      .clk(clk), .rst_n(rst_n), .clr(report_i), .inc(rd_new), .q(rd_q));
   idem_sat_cnt #(.W(CNT_W)) u_cnt_cf (
      .clk(clk), .rst_n(rst_n), .clr(report_i), .inc(cf_new), .q(cf_q));
   idem_sat_cnt #(.W(CNT_W)) u_cnt_stk (
      .clk(clk), .rst_n(rst_n), .clr(report_i), .inc(stk_new), .q(stk_q));

   logic [CYC_W-1:0] cyc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_o          <= 1'b0;
         overflow_o      <= 1'b0;
         cyc_q           <= '0;
         rpt_valid_o     <= 1'b0;
         rpt_writes_o    <= '0;
         rpt_reads_o     <= '0;
         rpt_conflicts_o <= '0;
         rpt_stack_o     <= '0;
         rpt_cycles_o    <= '0;
      end else begin
         viol_o      <= conflict;
         rpt_valid_o <= report_i;
         if (report_i) begin
            overflow_o      <= 1'b0;
            cyc_q           <= '0;
            rpt_writes_o    <= wr_q;
            rpt_reads_o     <= rd_q;
            rpt_conflicts_o <= cf_q;
            rpt_stack_o     <= stk_q;
            rpt_cycles_o    <= cyc_q + 1'b1;
         end else begin
            overflow_o <= overflow_o | drop_any;
            cyc_q      <= cyc_q + 1'b1;
         end
      end
   end

   // R4
   viol_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |-> $past(acc_valid_i && acc_write_i && !report_i));

   // R11
   rpt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid_o |-> $past(report_i));

   // R12
   ovf_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow_o) |-> !$past(report_i));

   // R6
   stack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stk_q <= cf_q);

   // R5
   conf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(report_i) |->
         ({1'b0, cf_q} == {1'b0, $past(cf_q)} ||
          {1'b0, cf_q} == {1'b0, $past(cf_q)} + 1'b1));
endmodule

// File: tb/idem_tracker_test.sv
module idem_tracker_test;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 30;
   localparam int CW = 16;
   localparam int YW = 32;
   localparam int SP = 'h1800;

   logic clk, rst_n;
   logic acc_valid, acc_write, acc_bypass;
   logic [AW-1:0] acc_addr, fetch_addr, sp;
   logic fetch_valid, report;
   logic viol, rpt_valid, overflow;
   logic [CW-1:0] rpt_w, rpt_r, rpt_c, rpt_s;
   logic [YW-1:0] rpt_cyc;

   idem_tracker uut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid_i(acc_valid), .acc_write_i(acc_write),
      .acc_bypass_i(acc_bypass), .acc_addr_i(acc_addr),
      .fetch_valid_i(fetch_valid), .fetch_addr_i(fetch_addr),
      .sp_i(sp), .report_i(report),
      .viol_o(viol), .rpt_valid_o(rpt_valid),
      .rpt_writes_o(rpt_w), .rpt_reads_o(rpt_r),
      .rpt_conflicts_o(rpt_c), .rpt_stack_o(rpt_s),
      .rpt_cycles_o(rpt_cyc), .overflow_o(overflow));

   typedef struct {
      int    w, r, c, s;
      int    cyc;
      string tag;
   } exp_t;

   exp_t sb[$];
   int n_checks = 0;
   int n_fail   = 0;
   int ecount   = 0;
   int last_rep = 0;

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) if (rst_n) ecount++;

   task automatic chk(input bit ok, input string req,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: pops expected snapshots as the design produces them
   always @(negedge clk) begin
      if (rst_n && rpt_valid) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R11 unexpected report", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(rpt_w == CW'(e.w), {e.tag, " writes"}, rpt_w, e.w);
            chk(rpt_r == CW'(e.r), {e.tag, " reads"}, rpt_r, e.r);
            chk(rpt_c == CW'(e.c), {e.tag, " conflicts"}, rpt_c, e.c);
            chk(rpt_s == CW'(e.s), {e.tag, " stack"}, rpt_s, e.s);
            chk(rpt_cyc == YW'(e.cyc), "R13 cycles", rpt_cyc, e.cyc);
         end
      end
   end

   task automatic acc(input bit w, input bit byp, input int a,
                      input bit ev, input string req);
      acc_valid = 1'b1; acc_write = w; acc_bypass = byp; acc_addr = AW'(a);
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; acc_bypass = 1'b0;
      chk(viol == ev, req, viol, ev);
   endtask

   task automatic fetch(input int a, input bit with_store, input int sa);
      fetch_valid = 1'b1; fetch_addr = AW'(a);
      if (with_store) begin
         acc_valid = 1'b1; acc_write = 1'b1; acc_addr = AW'(sa);
      end
      @(negedge clk);
      fetch_valid = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
   endtask

   task automatic do_report(input int w, input int r, input int c,
                            input int s, input bit with_load,
                            input int la, input string tag);
      exp_t e;
      e.w = w; e.r = r; e.c = c; e.s = s; e.tag = tag;
      e.cyc = ecount + 1 - last_rep;
      last_rep = ecount + 1;
      sb.push_back(e);
      report = 1'b1;
      if (with_load) begin
         acc_valid = 1'b1; acc_write = 1'b0; acc_addr = AW'(la);
      end
      @(negedge clk);
      report = 1'b0; acc_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures",
               n_checks, n_fail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      acc_valid = 1'b0; acc_write = 1'b0; acc_bypass = 1'b0;
      acc_addr = '0; fetch_valid = 1'b0; fetch_addr = '0;
      sp = AW'(SP); report = 1'b0;
      repeat (3) @(negedge clk);
      chk(viol == 1'b0, "R1 viol in reset", viol, 0);
      chk(overflow == 1'b0, "R1 overflow in reset", overflow, 0);
      rst_n = 1'b1;
      chk(rpt_valid == 1'b0, "R1 rpt_valid after reset", rpt_valid, 0);

      // interval 1
      acc(0, 0, 'h1010, 0, "R2 first load");
      acc(0, 0, 'h1010, 0, "R2 repeat load");
      acc(1, 0, 'h1020, 0, "R7 first store");
      acc(1, 0, 'h1020, 0, "R7 repeat store");
      acc(0, 0, 'h1020, 0, "R3 load after write");
      acc(1, 0, 'h1020, 0, "R3 store no violation");
      acc(1, 0, 'h1010, 1, "R4 store to read-first");
      acc(1, 0, 'h1010, 1, "R5 repeat conflict pulses");
      acc(0, 0, 'h17F8, 0, "R6 load at stack edge");
      acc(1, 0, 'h17F8, 1, "R6 conflict at stack edge");
      acc(0, 0, 'h17F7, 0, "R6 load below stack edge");
      acc(1, 0, 'h17F7, 1, "R6 conflict below stack edge");
      acc(0, 0, 'h0800, 0, "R9 load below window");
      acc(1, 0, 'h0800, 0, "R9 store below window");
      acc(0, 0, 'h2000, 0, "R9 load at window end");
      acc(0, 0, 'h1FFF, 0, "R9 load at last word");
      acc(0, 1, 'h1030, 0, "R10 bypass load");
      acc(1, 0, 'h1030, 0, "R10 store after bypass");
      acc(0, 0, 'h1FF0, 0, "R8 load ignore addr");
      acc(1, 0, 'h1FF0, 0, "R8 store ignore addr");
      fetch('h1040, 0, 0);
      fetch('h1050, 1, 'h1060);
      acc(1, 0, 'h1050, 0, "R14 colliding fetch dropped");
      acc(1, 0, 'h1040, 1, "R14 fetch tracked as load");
      do_report(4, 6, 4, 1, 0, 0, "R11 interval 1");

      // interval 2
      acc(1, 0, 'h1010, 0, "R11 sets emptied");
      do_report(1, 0, 0, 0, 1, 'h1070, "R11 interval 2");

      // interval 3
      acc(1, 0, 'h1070, 0, "R11 load in report cycle dropped");
      for (int i = 0; i < 16; i++) acc(0, 0, 'h1100 + i, 0, "R12 fill");
      chk(overflow == 1'b0, "R12 full set no overflow", overflow, 0);
      acc(0, 0, 'h1200, 0, "R12 load into full set");
      chk(overflow == 1'b1, "R12 overflow set", overflow, 1);
      acc(1, 0, 'h1200, 0, "R12 dropped entry not tracked");
      do_report(2, 16, 0, 0, 0, 0, "R12 interval 3");
      chk(overflow == 1'b0, "R12 overflow cleared", overflow, 0);
      do_report(0, 0, 0, 0, 0, 0, "R13 back-to-back");

      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R11 pending reports", sb.size(), 0);
      finish_run();
   end
endmodule